// File: doc/BRIEF.md
# Character-Cell Pixel Serializer

This block turns one character cell of a text display into a stream of four-bit pixel colors. On each character boundary an active-low load strobe captures an eight-bit glyph row, a color attribute byte and the cursor and blank qualifiers for that cell. The glyph row is then shifted out most significant bit first, one bit per pixel clock. Each bit is inverted when the cell holds the cursor. The result picks the foreground or background nibble of the attribute, and blanking forces the pixel to black.

The qualifiers are built inside the block. Cursor is the equality of the programmed cursor location and the current character address. Blank is the OR of the horizontal and vertical blanking flags. Both are registered on the same load strobe as the glyph and the attribute. Glyph, color, cursor and blank therefore pass through the same pipeline stages and leave the block aligned. A final output register, cleared synchronously for blanking and reset, drives the color pins toward the DAC.

The surrounding timing logic pulses the strobe low for one clock in every eight. It presents the address, flags, glyph row and attribute for the next cell during that clock.

Top module: `cell_pixel_serializer`

## Requirements
- R1: When the load strobe is sampled low and `char_addr` equals `cursor_loc`, every pixel of that cell has its glyph bit inverted. When they differ, no bit of that cell is inverted.
- R2: When the load strobe is sampled low and `hblank` or `vblank` is 1, every pixel of that cell is 0. When both are 0, the cell is not blanked.
- R3: Glyph row, attribute, address, cursor location and blank flags are sampled only on a clock edge where `load_n` is 0. Changes to them while `load_n` is 1 have no effect on the pixels of the current cell.
- R4: While `load_n` is 1 the glyph row shifts one bit per clock, most significant bit (bit 7) first, filling with 0.
- R5: The cursor inverts the serialized glyph bit before color selection, so a cursor cell shows bit value 0 as foreground and bit value 1 as background.
- R6: The attribute byte is split so that bits 7:4 are the foreground color, used when the effective bit is 1, and bits 3:0 are the background color, used when it is 0.
- R7: Blanking overrides color selection and clears the output register synchronously to 0.
- R8: If the strobe is sampled low at edge k, pixel i (i = 0..7, glyph bit 7-i) is on `pix_color` after edge k+2+i-1, that is from edge k+1 for pixel 0. Cursor and blank apply to exactly those eight pixels.
- R9: A synchronous active-high `rst` clears the glyph shifter, attribute, qualifiers and output, so `pix_color` is 0 after the first edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low character load strobe |
| glyph_row | input | 8 | Glyph row bits for the next cell |
| color_attr | input | 8 | Attribute: foreground in 7:4, background in 3:0 |
| char_addr | input | 14 | Character memory address of the next cell |
| cursor_loc | input | 14 | Programmed cursor location |
| hblank | input | 1 | Horizontal blanking flag |
| vblank | input | 1 | Vertical blanking flag |
| pix_color | output | 4 | Registered pixel color |

## Verification
The assertions assume that all inputs are stable around each rising edge. They also assume that the strobe is one clock wide and spaced eight clocks apart, so that each cell's eight pixels complete before the next load. The stimulus drives every input on the falling edge and issues loads back to back at exactly that spacing. Between loads it deliberately changes address, flags, glyph and attribute to show that they are ignored. The reference model takes only the values present during the load clock.

// File: rtl/cell_serializer_pkg.sv
package cell_serializer_pkg;

    // Source of the next pixel value
    typedef enum logic [1:0] {
        SRC_BG    = 2'd0,
        SRC_FG    = 2'd1,
        SRC_BLACK = 2'd2
    } pix_src_e;

    function automatic pix_src_e pick_source(input logic blank, input logic eff_bit);
        if (blank)
            return SRC_BLACK;
        else if (eff_bit)
            return SRC_FG;
        else
            return SRC_BG;
    endfunction

endpackage

// File: rtl/cell_qual_capture.sv
module cell_qual_capture #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] char_addr,
    input  logic [ADDR_W-1:0] cursor_loc,
    input  logic              hblank,
    input  logic              vblank,
    output logic              cursor_q,
    output logic              blank_q
);

    logic cursor_hit;
    logic blank_any;

    always_comb begin
        cursor_hit = (char_addr == cursor_loc);
        blank_any  = hblank | vblank;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cursor_q <= 1'b0;
            blank_q  <= 1'b0;
        end else if (!load_n) begin
            cursor_q <= cursor_hit;
            blank_q  <= blank_any;
        end
    end

    // R3: qualifiers hold between strobes
    a_r3_qual_hold: assert property (@(posedge clk) disable iff (rst)
        load_n |=> ($stable(cursor_q) && $stable(blank_q)));

    // R1: an address match at load marks the cell as cursor
    a_r1_cursor_take: assert property (@(posedge clk) disable iff (rst)
        (!load_n && (char_addr == cursor_loc)) |=> cursor_q);

    // R2: either blank flag at load blanks the cell
    a_r2_blank_take: assert property (@(posedge clk) disable iff (rst)
        (!load_n && (hblank || vblank)) |=> blank_q);

    a_r2_unblank_take: assert property (@(posedge clk) disable iff (rst)
        (!load_n && !hblank && !vblank) |=> !blank_q);

endmodule

// File: rtl/cell_glyph_shifter.sv
module cell_glyph_shifter #(
    parameter int GLYPH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_n,
    input  logic [GLYPH_W-1:0] glyph_row,
    output logic               glyph_bit
);

    localparam int MSB = GLYPH_W - 1;

    logic [GLYPH_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (!load_n)
            shreg <= glyph_row;
        else
            shreg <= {shreg[MSB-1:0], 1'b0};
    end

    assign glyph_bit = shreg[MSB];

    // R4: shift one place toward the MSB, zero fill
    a_r4_shift_step: assert property (@(posedge clk) disable iff (rst)
        load_n |=> (shreg == {$past(shreg[MSB-1:0]), 1'b0}));

    // R3: parallel capture only on the strobe
    a_r3_glyph_capture: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (shreg == $past(glyph_row)));

endmodule

// File: rtl/cell_attr_latch.sv
module cell_attr_latch #(
    parameter int COLOR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_n,
    input  logic [2*COLOR_W-1:0] color_attr,
    output logic [COLOR_W-1:0]   fg_color,
    output logic [COLOR_W-1:0]   bg_color
);

    logic [2*COLOR_W-1:0] attr_r;

    always_ff @(posedge clk) begin
        if (rst)
            attr_r <= '0;
        else if (!load_n)
            attr_r <= color_attr;
    end

    assign fg_color = attr_r[2*COLOR_W-1:COLOR_W];
    assign bg_color = attr_r[COLOR_W-1:0];

    // R3: attribute holds between strobes
    a_r3_attr_hold: assert property (@(posedge clk) disable iff (rst)
        load_n |=> $stable(attr_r));

endmodule

// File: rtl/cell_pixel_out.sv
module cell_pixel_out
    import cell_serializer_pkg::*;
#(
    parameter int COLOR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               glyph_bit,
    input  logic               cursor_q,
    input  logic               blank_q,
    input  logic [COLOR_W-1:0] fg_color,
    input  logic [COLOR_W-1:0] bg_color,
    output logic [COLOR_W-1:0] pix_color
);

    logic               eff_bit;
    pix_src_e           src;
    logic [COLOR_W-1:0] chosen;

    always_comb begin
        eff_bit = glyph_bit ^ cursor_q;
        src     = pick_source(blank_q, eff_bit);
        case (src)
            SRC_FG:  chosen = fg_color;
            SRC_BG:  chosen = bg_color;
            default: chosen = '0;
        endcase
    end

    // Output register with synchronous clear for reset and blanking
    always_ff @(posedge clk) begin
        if (rst || (src == SRC_BLACK))
            pix_color <= '0;
        else
            pix_color <= chosen;
    end

    // R7: blanked cells give black on the next edge
    a_r7_blank_black: assert property (@(posedge clk) disable iff (rst)
        blank_q |=> (pix_color == '0));

    // R5 / R6: a differing glyph bit and cursor select the foreground
    a_r5_fg_pick: assert property (@(posedge clk) disable iff (rst)
        (!blank_q && (glyph_bit != cursor_q)) |=> (pix_color == $past(fg_color)));

    // R6: equal glyph bit and cursor select the background
    a_r6_bg_pick: assert property (@(posedge clk) disable iff (rst)
        (!blank_q && (glyph_bit == cursor_q)) |=> (pix_color == $past(bg_color)));

    // R9: reset clears the output
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (pix_color == '0));

endmodule

// File: rtl/cell_pixel_serializer.sv
module cell_pixel_serializer #(
    parameter int GLYPH_W = 8,
    parameter int COLOR_W = 4,
    parameter int ADDR_W  = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_n,
    input  logic [GLYPH_W-1:0]   glyph_row,
    input  logic [2*COLOR_W-1:0] color_attr,
    input  logic [ADDR_W-1:0]    char_addr,
    input  logic [ADDR_W-1:0]    cursor_loc,
    input  logic                 hblank,
    input  logic                 vblank,
    output logic [COLOR_W-1:0]   pix_color
);

    logic               glyph_bit;
    logic               cursor_q;
    logic               blank_q;
    logic [COLOR_W-1:0] fg_color;
    logic [COLOR_W-1:0] bg_color;

    cell_qual_capture #(.ADDR_W(ADDR_W)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .char_addr  (char_addr),
        .cursor_loc (cursor_loc),
        .hblank     (hblank),
        .vblank     (vblank),
        .cursor_q   (cursor_q),
        .blank_q    (blank_q)
    );

    cell_glyph_shifter #(.GLYPH_W(GLYPH_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_n    (load_n),
        .glyph_row (glyph_row),
        .glyph_bit (glyph_bit)
    );

    cell_attr_latch #(.COLOR_W(COLOR_W)) u_attr (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .color_attr (color_attr),
        .fg_color   (fg_color),
        .bg_color   (bg_color)
    );

    cell_pixel_out #(.COLOR_W(COLOR_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .glyph_bit (glyph_bit),
        .cursor_q  (cursor_q),
        .blank_q   (blank_q),
        .fg_color  (fg_color),
        .bg_color  (bg_color),
        .pix_color (pix_color)
    );

endmodule

// File: tb/cell_pixel_serializer_bench.sv
module cell_pixel_serializer_bench;

    localparam int CURSOR_AT = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_n = 1'b1;
    logic [7:0]  glyph_row = '0;
    logic [7:0]  color_attr = '0;
    logic [13:0] char_addr = '0;
    logic [13:0] cursor_loc = 14'(CURSOR_AT);
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic [3:0]  pix_color;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    typedef struct {
        int       due;
        logic [3:0] val;
        string    req;
    } exp_t;

    exp_t sb[$];

    cell_pixel_serializer u_cell_pixel_serializer (
        .clk        (clk),
        .rst        (rst),
        .load_n     (load_n),
        .glyph_row  (glyph_row),
        .color_attr (color_attr),
        .char_addr  (char_addr),
        .cursor_loc (cursor_loc),
        .hblank     (hblank),
        .vblank     (vblank),
        .pix_color  (pix_color)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input logic [3:0] got, input logic [3:0] want, input string req);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: pix_color=%0h expected %0h at cycle %0d", req, got, want, cyc);
        end
    endtask

    // Monitor: pop expected pixels as they fall due
    always @(negedge clk) begin
        if (!done) begin
            while (sb.size() > 0 && sb[0].due < cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: pixel due at %0d not sampled, expected %0h", sb[0].req, sb[0].due, sb[0].val);
                void'(sb.pop_front());
            end
            if (sb.size() > 0 && sb[0].due == cyc) begin
                check(pix_color, sb[0].val, sb[0].req);
                void'(sb.pop_front());
            end
        end
    end

    // Driver: one cell, eight clocks; optional disturbance between loads (R3)
    task automatic send_cell(input logic [7:0] g, input logic [7:0] c, input logic [13:0] a,
                             input logic hb, input logic vb, input bit disturb, input string req);
        logic cur;
        logic blk;
        @(negedge clk);
        load_n     = 1'b0;
        glyph_row  = g;
        color_attr = c;
        char_addr  = a;
        hblank     = hb;
        vblank     = vb;
        cur = (a == cursor_loc);
        blk = hb | vb;
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            logic b;
            b     = g[7-i] ^ cur;
            e.due = cyc + 2 + i;
            e.val = blk ? 4'h0 : (b ? c[7:4] : c[3:0]);
            e.req = req;
            sb.push_back(e);
        end
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            load_n = 1'b1;
            if (disturb) begin
                glyph_row  = ~g;
                color_attr = ~c;
                char_addr  = cur ? a + 14'd1 : cursor_loc;
                hblank     = ~hb;
                vblank     = ~vb;
            end
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check(pix_color, 4'h0, "R9 reset");
        rst = 1'b0;

        send_cell(8'hA5, 8'h92, 14'd10, 1'b0, 1'b0, 0, "R6 fg/bg split");
        send_cell(8'h3C, 8'hE1, 14'd11, 1'b0, 1'b0, 0, "R4 msb-first shift");
        send_cell(8'hF0, 8'h7A, 14'(CURSOR_AT), 1'b0, 1'b0, 0, "R5 cursor invert");
        send_cell(8'h81, 8'h5C, 14'(CURSOR_AT + 1), 1'b0, 1'b0, 0, "R1 near miss");
        send_cell(8'hFF, 8'hF3, 14'd20, 1'b1, 1'b0, 0, "R7 hblank black");
        send_cell(8'h0F, 8'hB4, 14'd21, 1'b0, 1'b1, 0, "R2 vblank");
        send_cell(8'h96, 8'h4B, 14'd12, 1'b0, 1'b0, 1, "R3 hold plain");
        send_cell(8'h00, 8'hC6, 14'(CURSOR_AT), 1'b0, 1'b0, 1, "R3 hold cursor");
        send_cell(8'h55, 8'hDE, 14'(CURSOR_AT), 1'b1, 1'b1, 0, "R7 cursor under blank");
        send_cell(8'h80, 8'hA0, 14'd30, 1'b0, 1'b0, 0, "R8 single pixel");
        send_cell(8'h01, 8'hA0, 14'd31, 1'b0, 1'b0, 0, "R8 last pixel");
        for (int n = 0; n < 24; n++) begin
            logic [7:0]  g;
            logic [7:0]  c;
            logic [13:0] a;
            logic [1:0]  f;
            g = 8'($urandom);
            c = 8'($urandom);
            a = (n % 3 == 0) ? 14'(CURSOR_AT) : 14'($urandom_range(0, 400));
            f = ((n % 5) == 2) ? 2'($urandom_range(1, 3)) : 2'b00;
            send_cell(g, c, a, f[0], f[1], n[0], "R8 mixed stream");
        end
        send_cell(8'h00, 8'h3D, 14'd40, 1'b0, 1'b0, 0, "R8 tail");

        while (sb.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check(pix_color, 4'hD, "R4 zero fill after cell");
        rst = 1'b1;
        @(negedge clk);
        check(pix_color, 4'h0, "R9 reset mid-run");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule